// File: doc/BRIEF.md
# Dual-Clock FIFO with Flush Propagation

This block is a first-in first-out queue whose producer and consumer sit on two unrelated clocks. The producer side pushes words with a write strobe and sees how many entries are occupied. The consumer side sees a ready flag, the head word, its own occupancy count and a reset flag. Read and write pointers are kept in Gray code and pass into the opposite domain through chains of flip-flops.

Only the producer domain has an external reset. Asserting it empties the queue at once on the producer side. The same reset is also carried into the consumer domain through a reset bridge that asserts at once and releases after a fixed number of consumer clock edges. The bridge output is driven out as a consumer-side reset flag, so that downstream logic can tell that the queue was flushed. The same mechanism marks the end of the consumer domain's power-on reset.

The head word is visible on the read data port while the ready flag is high. A read strobe sampled high together with ready pops the word on the next consumer clock edge.

Top module: `xclk_fifo`

## Requirements
- R1: While `wr_rst` is high at power-up, `rd_rst_out` is high. After `wr_rst` falls, `rd_rst_out` falls after SYNC_STAGES rising edges of `rd_clk` (one fewer if an edge coincides with the release).
- R2: A `wr_rst` pulse lasting one `wr_clk` cycle raises `rd_rst_out` without waiting for a `rd_clk` edge. `rd_rst_out` then falls after SYNC_STAGES rising edges of `rd_clk`.
- R3: After a `wr_rst` pulse, `wr_level` reads 0 and stays 0 on every write cycle while `wr_en` stays low.
- R4: After `rd_rst_out` falls following a flush, `rd_level` reads 0 and `rd_ready` stays low on every read cycle until new data is written.
- R5: While `rd_rst_out` is high, `rd_ready` is 0, `rd_data` is all zeros and `rd_level` is 0.
- R6: Words come out in the order they were written. `wr_level` counts accepted writes not yet seen as read. `rd_ready` rises once written data has crossed into the read domain, and falls when the queue is seen as empty.
- R7: A write while `wr_level` equals DEPTH is dropped: the level stays at DEPTH and only the first DEPTH words come out. Neither level ever exceeds DEPTH.
- R8: `rd_en` while `rd_ready` is low is ignored. `rd_level` stays 0, and the next word written is the next word read.
- R9: R2 to R6 hold when the read clock equals the write clock, when it is 2.7 times slower, and when it is 2.7 times faster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Active-high reset, synchronous to `wr_clk`; flushes the queue |
| wr_en | input | 1 | Write strobe; pushes `wr_data` on the rising `wr_clk` edge unless full |
| wr_data | input | WIDTH | Word to push |
| wr_level | output | $clog2(DEPTH)+1 | Occupancy as seen from the write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read strobe; pops the head word on the rising `rd_clk` edge when `rd_ready` is high |
| rd_ready | output | 1 | Head word is valid |
| rd_data | output | WIDTH | Head word; zero while `rd_ready` is low |
| rd_level | output | $clog2(DEPTH)+1 | Occupancy as seen from the read domain |
| rd_rst_out | output | 1 | Read-domain reset flag carried over from `wr_rst` |

## Verification
Short bursts with matched, slower and faster read clocks show whether the Gray pointer crossing keeps words in order at every clock ratio. Bursts longer than the depth, and reads against an empty queue, tell a dropped operation apart from a pointer that silently wraps or slips. Single-cycle flush pulses issued while data sits in the queue separate a correct flush (levels cleared on both sides, read reset held for exactly the bridge length) from a flush that leaves stale words, or that never reaches the read domain. A final push after each flush shows that both pointers restart together.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

   // Reset flavour of a synchronizer chain.
   typedef enum logic {
      RST_SYNC  = 1'b0,
      RST_ASYNC = 1'b1
   } rst_style_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/xclk_ptr_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer; delivers the binary value.
module xclk_ptr_sync
   import xclk_fifo_pkg::*;
#(
   parameter int         W      = 4,
   parameter int         STAGES = 2,
   parameter rst_style_e STYLE  = RST_SYNC
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);

   logic [W-1:0] stage_q [STAGES];

   generate
      if (STYLE == RST_ASYNC) begin : g_async
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= gray_in;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= gray_in;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   // Gray to binary: each bit is the XOR of all Gray bits at or above it.
   always_comb begin
      for (int i = 0; i < W; i++) bin_out[i] = ^(stage_q[STAGES-1] >> i);
   end

endmodule

// File: rtl/xclk_rst_bridge.sv
// Asynchronous-assert, synchronous-release reset carrier into a foreign clock.
module xclk_rst_bridge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_out
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain_q <= '1;
      else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
   end

   assign rst_out = chain_q[STAGES-1];

endmodule

// File: rtl/xclk_wr_side.sv
// Producer-domain pointer, full detection and occupancy.
module xclk_wr_side
   import xclk_fifo_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 3,
   parameter int SYNC  = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [AW:0]   rd_gray,
   output logic [AW:0]   wr_gray_q,
   output logic [AW-1:0] waddr,
   output logic          accept,
   output logic [AW:0]   level
);

   localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

   logic [AW:0] bin_q, bin_nxt, rd_bin;

   xclk_ptr_sync #(.W(AW+1), .STAGES(SYNC), .STYLE(RST_SYNC)) u_rsync (
      .clk     (clk),
      .rst     (rst),
      .gray_in (rd_gray),
      .bin_out (rd_bin)
   );

   assign level   = bin_q - rd_bin;
   assign accept  = en && (level != FULL_LVL);
   assign bin_nxt = bin_q + {{AW{1'b0}}, accept};
   assign waddr   = bin_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         bin_q     <= '0;
         wr_gray_q <= '0;
      end else begin
         bin_q     <= bin_nxt;
         wr_gray_q <= bin_nxt ^ (bin_nxt >> 1);
      end
   end

endmodule

// File: rtl/xclk_rd_side.sv
// Consumer-domain pointer, empty detection and occupancy.
module xclk_rd_side
   import xclk_fifo_pkg::*;
#(
   parameter int AW   = 3,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [AW:0]   wr_gray,
   output logic [AW:0]   rd_gray_q,
   output logic [AW-1:0] raddr,
   output logic          ready,
   output logic [AW:0]   level
);

   logic [AW:0] bin_q, bin_nxt, wr_bin;
   logic        accept;

   xclk_ptr_sync #(.W(AW+1), .STAGES(SYNC), .STYLE(RST_ASYNC)) u_wsync (
      .clk     (clk),
      .rst     (rst),
      .gray_in (wr_gray),
      .bin_out (wr_bin)
   );

   assign level   = wr_bin - bin_q;
   assign ready   = !rst && (level != '0);
   assign accept  = en && ready;
   assign bin_nxt = bin_q + {{AW{1'b0}}, accept};
   assign raddr   = bin_q[AW-1:0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         bin_q     <= '0;
         rd_gray_q <= '0;
      end else begin
         bin_q     <= bin_nxt;
         rd_gray_q <= bin_nxt ^ (bin_nxt >> 1);
      end
   end

endmodule

// File: rtl/xclk_fifo.sv
// Dual-clock FIFO; the producer reset flushes it and is reported on the consumer side.
module xclk_fifo
   import xclk_fifo_pkg::*;
#(
   parameter int WIDTH       = 1,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int LW         = AW + 1
) (
   input  logic             wr_clk,
   input  logic             wr_rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [LW-1:0]    wr_level,
   input  logic             rd_clk,
   input  logic             rd_en,
   output logic             rd_ready,
   output logic [WIDTH-1:0] rd_data,
   output logic [LW-1:0]    rd_level,
   output logic             rd_rst_out
);

   generate
      if (!is_pow2(DEPTH)) begin : g_bad_depth
         $error("xclk_fifo: DEPTH must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xclk_fifo: SYNC_STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("xclk_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [LW-1:0]    wr_gray, rd_gray;
   logic [AW-1:0]    waddr, raddr;
   logic             wr_accept;
   logic [WIDTH-1:0] mem_q [DEPTH];

   xclk_rst_bridge #(.STAGES(SYNC_STAGES)) u_rbridge (
      .clk     (rd_clk),
      .arst    (wr_rst),
      .rst_out (rd_rst_out)
   );

   xclk_wr_side #(.DEPTH(DEPTH), .AW(AW), .SYNC(SYNC_STAGES)) u_wr (
      .clk       (wr_clk),
      .rst       (wr_rst),
      .en        (wr_en),
      .rd_gray   (rd_gray),
      .wr_gray_q (wr_gray),
      .waddr     (waddr),
      .accept    (wr_accept),
      .level     (wr_level)
   );

   xclk_rd_side #(.AW(AW), .SYNC(SYNC_STAGES)) u_rd (
      .clk       (rd_clk),
      .rst       (rd_rst_out),
      .en        (rd_en),
      .wr_gray   (wr_gray),
      .rd_gray_q (rd_gray),
      .raddr     (raddr),
      .ready     (rd_ready),
      .level     (rd_level)
   );

   always_ff @(posedge wr_clk) begin
      if (wr_accept) mem_q[waddr] <= wr_data;
   end

   assign rd_data = rd_ready ? mem_q[raddr] : '0;

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
   parameter int WIDTH = 1,
   parameter int DEPTH = 8,
   parameter int LW    = 4
) (
   input logic             wr_clk,
   input logic             wr_rst,
   input logic             wr_en,
   input logic [LW-1:0]    wr_level,
   input logic             rd_clk,
   input logic             rd_en,
   input logic             rd_ready,
   input logic [WIDTH-1:0] rd_data,
   input logic [LW-1:0]    rd_level,
   input logic             rd_rst_out
);

   p_wr_cap_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_level <= LW'(DEPTH));

   p_rd_cap_r7: assert property (@(posedge rd_clk) disable iff (rd_rst_out)
      rd_level <= LW'(DEPTH));

   p_idle_no_growth_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
      !wr_en |=> wr_level <= $past(wr_level));

   p_quiet_in_reset_r5: assert property (@(posedge rd_clk) disable iff (wr_rst)
      rd_rst_out |-> (!rd_ready && rd_data == '0 && rd_level == '0));

   p_idle_no_shrink_r8: assert property (@(posedge rd_clk) disable iff (rd_rst_out)
      !rd_en |=> rd_level >= $past(rd_level));

   p_ready_has_data_r6: assert property (@(posedge rd_clk) disable iff (rd_rst_out)
      rd_ready |-> rd_level != '0);

endmodule

bind xclk_fifo xclk_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LW(LW)) u_chk (
   .wr_clk     (wr_clk),
   .wr_rst     (wr_rst),
   .wr_en      (wr_en),
   .wr_level   (wr_level),
   .rd_clk     (rd_clk),
   .rd_en      (rd_en),
   .rd_ready   (rd_ready),
   .rd_data    (rd_data),
   .rd_level   (rd_level),
   .rd_rst_out (rd_rst_out)
);

// File: tb/sim_xclk_fifo.sv
`timescale 1ns/1ps
module sim_xclk_fifo;

   localparam int W  = 1;
   localparam int D  = 8;
   localparam int S  = 2;
   localparam int LW = $clog2(D) + 1;

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          wr_rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic          rd_en = 1'b0;
   logic [LW-1:0] wr_level, rd_level;
   logic          rd_ready, rd_rst_out;
   logic [W-1:0]  rd_data;

   realtime rd_half = 2.0;
   int      checks = 0;
   int      errs   = 0;
   bit      done   = 1'b0;

   always #2 wr_clk = ~wr_clk;              // 250 MHz
   always begin
      #(rd_half) rd_clk = ~rd_clk;
   end

   xclk_fifo #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(S)) u0 (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
      .wr_level(wr_level), .rd_clk(rd_clk), .rd_en(rd_en), .rd_ready(rd_ready),
      .rd_data(rd_data), .rd_level(rd_level), .rd_rst_out(rd_rst_out)
   );

   function automatic logic [W-1:0] pat(input int k);
      return W'(k ^ (k >> 1) ^ (k >> 3));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_burst(input int n, input int base);
      @(negedge wr_clk);
      for (int k = 0; k < n; k++) begin
         wr_en = 1'b1;
         wr_data = pat(base + k);
         @(negedge wr_clk);
      end
      wr_en = 1'b0;
   endtask

   task automatic rd_pop_check(input int n, input int base, input string req);
      @(negedge rd_clk);
      for (int k = 0; k < n; k++) begin
         int t = 0;
         while (!rd_ready && t < 500) begin
            @(negedge rd_clk);
            t++;
         end
         chk(req, 32'(rd_ready), 32'd1);
         chk(req, 32'(rd_data), 32'(pat(base + k)));
         rd_en = 1'b1;
         @(negedge rd_clk);
         rd_en = 1'b0;
      end
   endtask

   task automatic wait_rd_level(input int v);
      int t = 0;
      @(negedge rd_clk);
      while (rd_level != LW'(v) && t < 500) begin
         @(negedge rd_clk);
         t++;
      end
   endtask

   // Counts rd_clk rising edges until rd_rst_out falls; checks R5 meanwhile.
   task automatic count_release(input string req, output int cnt);
      cnt = 0;
      while (rd_rst_out && cnt < 50) begin
         @(posedge rd_clk);
         #0.01;
         cnt++;
         if (rd_rst_out) begin
            chk("R5", 32'(rd_ready), 32'd0);
            chk("R5", 32'(rd_data), 32'd0);
         end
      end
      chk(req, 32'(cnt >= S - 1 && cnt <= S), 32'd1);
   endtask

   task automatic t_power_up;
      int cnt;
      repeat (3) @(negedge wr_clk);
      chk("R1", 32'(rd_rst_out), 32'd1);
      chk("R5", 32'(rd_ready), 32'd0);
      chk("R5", 32'(rd_level), 32'd0);
      chk("R3", 32'(wr_level), 32'd0);
      wr_rst = 1'b0;
      count_release("R1", cnt);
      chk("R1", 32'(rd_rst_out), 32'd0);
      @(negedge rd_clk);
      chk("R4", 32'(rd_level), 32'd0);
   endtask

   task automatic t_stream(input realtime half, input int base);
      rd_half = half;
      repeat (4) @(negedge wr_clk);
      wr_burst(5, base);
      chk("R6", 32'(wr_level), 32'd5);
      wait_rd_level(5);
      chk("R6", 32'(rd_level), 32'd5);
      rd_pop_check(5, base, "R6 R9");
      repeat (3) @(negedge rd_clk);
      chk("R6", 32'(rd_ready), 32'd0);
      repeat (4) @(negedge wr_clk);
      chk("R6", 32'(wr_level), 32'd0);
   endtask

   task automatic t_overflow(input int base);
      rd_half = 2.0;
      repeat (4) @(negedge wr_clk);
      wr_burst(D + 3, base);
      chk("R7", 32'(wr_level), 32'(D));
      wait_rd_level(D);
      chk("R7", 32'(rd_level), 32'(D));
      rd_pop_check(D, base, "R7");
      repeat (3) @(negedge rd_clk);
      chk("R8", 32'(rd_ready), 32'd0);
      rd_en = 1'b1;
      repeat (4) @(negedge rd_clk);
      rd_en = 1'b0;
      chk("R8", 32'(rd_level), 32'd0);
      wr_burst(1, base + 100);
      rd_pop_check(1, base + 100, "R8");
   endtask

   task automatic t_flush(input realtime half, input int base);
      int t;
      int cnt;
      rd_half = half;
      repeat (4) @(negedge wr_clk);
      wr_burst(4, base);
      t = 0;
      while (!rd_ready && t < 500) begin
         @(negedge rd_clk);
         t++;
      end
      chk("R6", 32'(rd_ready), 32'd1);
      @(negedge wr_clk);
      wr_rst = 1'b1;
      #0.1;
      chk("R2", 32'(rd_rst_out), 32'd1);
      @(negedge wr_clk);
      wr_rst = 1'b0;
      count_release("R2 R9", cnt);
      for (int k = 0; k < 10; k++) begin
         @(negedge wr_clk);
         chk("R3", 32'(wr_level), 32'd0);
      end
      for (int k = 0; k < 10; k++) begin
         @(negedge rd_clk);
         chk("R4", 32'(rd_level), 32'd0);
         chk("R4", 32'(rd_ready), 32'd0);
      end
      wr_burst(2, base + 50);
      rd_pop_check(2, base + 50, "R9");
   endtask

   initial begin
      t_power_up();
      t_stream(2.0, 0);
      t_stream(5.4, 10);
      t_stream(0.74, 20);
      t_overflow(30);
      t_flush(2.0, 200);
      t_flush(5.4, 300);
      t_flush(0.74, 400);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL R9 watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

endmodule